// File: doc/BRIEF.md
# SRAM Self-Test Sequencer

This block is a built-in test controller for one single-port synchronous SRAM with 32-bit words. When `start` is pulsed, it latches an inclusive address window. It then runs five test algorithms over that window, one after another. It drives the SRAM port directly, checks every read word one cycle after issuing the read, and stops at the first word that differs from the value it expects.

On a stop it reports four things: the address, the expected word, the word that came back, and the algorithm that was running. It also reports whether the miss happened on a first verify pass or on a second, retention-style pass over data already checked once. A clean run ends in `done`. Either final state holds until the next `start`.

The five algorithms run in this order:

1. Four fixed words.
2. Word/complement pairs.
3. Address-as-data.
4. A walking one in every bit of every word.
5. A pseudo-random fill.

Top module: `mbist_engine`

## Requirements
- R1: After reset, `busy`, `done`, `fail` and `mem_en` are low.
- R2: For a window of N words, a clean run makes exactly 90*N memory accesses, of which 42*N are writes. `busy` stays high for exactly 90*N+1 cycles and is followed by `done`.
- R3: Fixed-word algorithm (`fail_alg`=0). For each of the words 0x00000000, 0xFFFFFFFF, 0xAA55AA55 and 0x55AA55AA, in that order, it writes the word to the whole window and then reads the window once. A stuck-at-1 bit therefore fails on 0x00000000, and a stuck-at-0 bit fails on 0xFFFFFFFF.
- R4: Pair algorithm (`fail_alg`=1). For each of the same four words, it writes the word at addresses with an even offset from the window start and the complement at odd offsets. It then reads the window twice.
- R5: A miss on a second read pass sets `fail_second`=1. A miss on a first read pass sets `fail_second`=0.
- R6: Address algorithm (`fail_alg`=2). It writes each word with its own address, zero-extended, then reads the window twice.
- R7: Walking algorithm (`fail_alg`=3). At each address in turn, for bit 0 up to bit 31, it writes a word with only that bit set and reads it back before moving to the next bit.
- R8: Random algorithm (`fail_alg`=4). It writes the window with successive states of a 32-bit register, then reads it twice. The register starts at 0xC0FFEE01 at the start of every pass and steps per address as s' = (s>>1) ^ (s[0] ? 0x80200003 : 0). After a clean run, the window holds this sequence.
- R9: The first miss ends the run with `fail` high. At that point `fail_addr`, `fail_exp`, `fail_got` and `fail_alg` describe that miss. The report and `fail` hold until the next `start`.
- R10: Only addresses inside the inclusive window are accessed. A window with start above end finishes with `done` after one busy cycle and no access.
- R11: `start` is ignored while `busy` is high.
- R12: A `start` after `done` or `fail` begins a fresh run, with `fail` and `fail_second` cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| range_lo | input | ADDR_W | First address of the window |
| range_hi | input | ADDR_W | Last address of the window (inclusive) |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write enable (read when low) |
| mem_addr | output | ADDR_W | SRAM address |
| mem_wdata | output | DATA_W | SRAM write data |
| mem_rdata | input | DATA_W | SRAM read data, valid the cycle after a read |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished with no miss |
| fail | output | 1 | Run stopped on a miss |
| fail_second | output | 1 | Miss was on a second read pass |
| fail_alg | output | 3 | Algorithm of the miss (0 fixed, 1 pair, 2 address, 3 walking, 4 random) |
| fail_addr | output | ADDR_W | Address of the miss |
| fail_exp | output | DATA_W | Expected word |
| fail_got | output | DATA_W | Word read |

## Verification
Each injected memory fault is meant to slip past every algorithm but one, so the reported `fail_alg` shows which algorithm catches what:

- A stuck-at bit is caught by the fixed words, and its polarity picks 0x00000000 or 0xFFFFFFFF as the failing word.
- A write that also lands on the neighbouring lower address is caught only by the pair algorithm.
- A write that lands two addresses lower is caught only by address-as-data.
- A read that ORs bit 20 into bit 4 is caught only by the walking one.
- A cell that flips after its fifth read separates the second-pass error class from the first.

Clean runs over random windows check access counts, busy length, final random contents and untouched neighbours. Further directed runs cover the full address space, an empty window and a start pulse mid-run.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    typedef enum logic [2:0] {
        ALG_FIX = 3'd0,
        ALG_PAIR = 3'd1,
        ALG_ADR = 3'd2,
        ALG_WALK = 3'd3,
        ALG_RND = 3'd4
    } alg_e;

    typedef enum logic [1:0] {
        PH_WR  = 2'd0,
        PH_RD1 = 2'd1,
        PH_RD2 = 2'd2
    } phase_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RUN   = 3'd1,
        ST_DRAIN = 3'd2,
        ST_DONE  = 3'd3,
        ST_FAIL  = 3'd4
    } state_e;

    localparam int unsigned NUM_WORDS = 4;

endpackage

// File: rtl/mbist_lfsr.sv
module mbist_lfsr #(
    parameter int unsigned    DATA_W = 32,
    parameter logic [DATA_W-1:0] SEED = 32'hC0FFEE01,
    parameter logic [DATA_W-1:0] TAPS = 32'h80200003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    output logic [DATA_W-1:0] state
);
    logic [DATA_W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = lfsr_q;
        if (load) begin
            lfsr_d = SEED;
        end else if (step) begin
            lfsr_d = (lfsr_q >> 1) ^ (lfsr_q[0] ? TAPS : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign state = lfsr_q;

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);  // R8
endmodule

// File: rtl/mbist_datagen.sv
module mbist_datagen
    import mbist_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned BIT_W = $clog2(DATA_W)
) (
    input  alg_e              alg,
    input  logic [1:0]        word_sel,
    input  logic              odd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BIT_W-1:0]  bit_sel,
    input  logic [DATA_W-1:0] rnd,
    output logic [DATA_W-1:0] data
);
    logic [DATA_W-1:0] fixed_word;

    always_comb begin
        case (word_sel)
            2'd0:    fixed_word = '0;
            2'd1:    fixed_word = '1;
            2'd2:    fixed_word = {(DATA_W/16){16'hAA55}};
            default: fixed_word = {(DATA_W/16){16'h55AA}};
        endcase
    end

    always_comb begin
        case (alg)
            ALG_FIX:  data = fixed_word;
            ALG_PAIR: data = odd ? ~fixed_word : fixed_word;
            ALG_ADR:  data = DATA_W'(addr);
            ALG_WALK: data = DATA_W'(1) << bit_sel;
            default:  data = rnd;
        endcase
    end
endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp
    import mbist_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_issue,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_exp,
    input  logic              rd_second,
    input  alg_e              rd_alg,
    input  logic [DATA_W-1:0] rdata,
    output logic              mis,
    output logic [ADDR_W-1:0] mis_addr,
    output logic [DATA_W-1:0] mis_exp,
    output logic              mis_second,
    output alg_e              mis_alg
);
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] exp;
        logic              second;
        alg_e              alg;
    } pend_t;

    pend_t pend_d, pend_q;

    always_comb begin
        pend_d.vld    = rd_issue;
        pend_d.addr   = rd_addr;
        pend_d.exp    = rd_exp;
        pend_d.second = rd_second;
        pend_d.alg    = rd_alg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign mis        = pend_q.vld && (rdata != pend_q.exp);
    assign mis_addr   = pend_q.addr;
    assign mis_exp    = pend_q.exp;
    assign mis_second = pend_q.second;
    assign mis_alg    = pend_q.alg;

    AST_MISS_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mis |-> $past(rd_issue));  // R9
endmodule

// File: rtl/mbist_engine.sv
module mbist_engine
    import mbist_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter logic [DATA_W-1:0] LFSR_SEED = 32'hC0FFEE01,
    parameter logic [DATA_W-1:0] LFSR_TAPS = 32'h80200003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] range_lo,
    input  logic [ADDR_W-1:0] range_hi,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic              fail_second,
    output logic [2:0]        fail_alg,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_exp,
    output logic [DATA_W-1:0] fail_got
);
    localparam int unsigned BIT_W   = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);
    localparam logic [1:0] WORD_LAST = 2'(NUM_WORDS - 1);

    typedef struct packed {
        state_e            st;
        alg_e              alg;
        phase_e            ph;
        logic [1:0]        wsel;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
        logic [BIT_W-1:0]  bitn;
        logic              wrd;
        logic              fsec;
        alg_e              falg;
        logic [ADDR_W-1:0] faddr;
        logic [DATA_W-1:0] fexp;
        logic [DATA_W-1:0] fgot;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              lfsr_load, lfsr_step;
    logic [DATA_W-1:0] rnd_word, gen_word;
    logic              rd_issue, last_addr;
    logic              mis, mis_second;
    logic [ADDR_W-1:0] mis_addr;
    logic [DATA_W-1:0] mis_exp;
    alg_e              mis_alg;

    mbist_lfsr #(.DATA_W(DATA_W), .SEED(LFSR_SEED), .TAPS(LFSR_TAPS)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .load(lfsr_load), .step(lfsr_step), .state(rnd_word)
    );

    mbist_datagen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gen (
        .alg(ctl_q.alg), .word_sel(ctl_q.wsel), .odd(ctl_q.addr[0] ^ ctl_q.lo[0]),
        .addr(ctl_q.addr), .bit_sel(ctl_q.bitn), .rnd(rnd_word), .data(gen_word)
    );

    mbist_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .rd_issue(rd_issue), .rd_addr(ctl_q.addr),
        .rd_exp(gen_word), .rd_second(ctl_q.ph == PH_RD2), .rd_alg(ctl_q.alg),
        .rdata(mem_rdata), .mis(mis), .mis_addr(mis_addr), .mis_exp(mis_exp),
        .mis_second(mis_second), .mis_alg(mis_alg)
    );

    assign mem_en    = (ctl_q.st == ST_RUN);
    assign mem_we    = (ctl_q.alg == ALG_WALK) ? ~ctl_q.wrd : (ctl_q.ph == PH_WR);
    assign mem_addr  = ctl_q.addr;
    assign mem_wdata = gen_word;
    assign rd_issue  = mem_en && !mem_we;
    assign last_addr = (ctl_q.addr == ctl_q.hi);

    always_comb begin
        ctl_d     = ctl_q;
        lfsr_load = 1'b0;
        lfsr_step = 1'b0;
        case (ctl_q.st)
            ST_RUN: begin
                if (ctl_q.alg == ALG_WALK) begin
                    if (!ctl_q.wrd) begin
                        ctl_d.wrd = 1'b1;
                    end else begin
                        ctl_d.wrd = 1'b0;
                        if (ctl_q.bitn != BIT_LAST) begin
                            ctl_d.bitn = ctl_q.bitn + 1'b1;
                        end else begin
                            ctl_d.bitn = '0;
                            if (last_addr) begin
                                ctl_d.alg  = ALG_RND;
                                ctl_d.ph   = PH_WR;
                                ctl_d.addr = ctl_q.lo;
                                lfsr_load  = 1'b1;
                            end else begin
                                ctl_d.addr = ctl_q.addr + 1'b1;
                            end
                        end
                    end
                end else if (!last_addr) begin
                    ctl_d.addr = ctl_q.addr + 1'b1;
                    lfsr_step  = (ctl_q.alg == ALG_RND);
                end else begin
                    ctl_d.addr = ctl_q.lo;
                    lfsr_load  = 1'b1;
                    if (ctl_q.ph == PH_WR) begin
                        ctl_d.ph = PH_RD1;
                    end else if (ctl_q.ph == PH_RD1 && ctl_q.alg != ALG_FIX) begin
                        ctl_d.ph = PH_RD2;
                    end else begin
                        ctl_d.ph = PH_WR;
                        case (ctl_q.alg)
                            ALG_FIX: begin
                                ctl_d.wsel = ctl_q.wsel + 1'b1;
                                if (ctl_q.wsel == WORD_LAST) ctl_d.alg = ALG_PAIR;
                            end
                            ALG_PAIR: begin
                                ctl_d.wsel = ctl_q.wsel + 1'b1;
                                if (ctl_q.wsel == WORD_LAST) ctl_d.alg = ALG_ADR;
                            end
                            ALG_ADR: begin
                                ctl_d.alg  = ALG_WALK;
                                ctl_d.bitn = '0;
                                ctl_d.wrd  = 1'b0;
                            end
                            default: ctl_d.st = ST_DRAIN;
                        endcase
                    end
                end
            end
            ST_DRAIN: ctl_d.st = ST_DONE;
            default: begin
                if (start) begin
                    ctl_d.st    = (range_lo > range_hi) ? ST_DRAIN : ST_RUN;
                    ctl_d.alg   = ALG_FIX;
                    ctl_d.ph    = PH_WR;
                    ctl_d.wsel  = '0;
                    ctl_d.bitn  = '0;
                    ctl_d.wrd   = 1'b0;
                    ctl_d.lo    = range_lo;
                    ctl_d.hi    = range_hi;
                    ctl_d.addr  = range_lo;
                    ctl_d.fsec  = 1'b0;
                    ctl_d.falg  = ALG_FIX;
                    ctl_d.faddr = '0;
                    ctl_d.fexp  = '0;
                    ctl_d.fgot  = '0;
                    lfsr_load   = 1'b1;
                end
            end
        endcase
        if (mis && (ctl_q.st == ST_RUN || ctl_q.st == ST_DRAIN)) begin
            ctl_d.st    = ST_FAIL;
            ctl_d.fsec  = mis_second;
            ctl_d.falg  = mis_alg;
            ctl_d.faddr = mis_addr;
            ctl_d.fexp  = mis_exp;
            ctl_d.fgot  = mem_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign busy        = (ctl_q.st == ST_RUN) || (ctl_q.st == ST_DRAIN);
    assign done        = (ctl_q.st == ST_DONE);
    assign fail        = (ctl_q.st == ST_FAIL);
    assign fail_second = ctl_q.fsec;
    assign fail_alg    = ctl_q.falg;
    assign fail_addr   = ctl_q.faddr;
    assign fail_exp    = ctl_q.fexp;
    assign fail_got    = ctl_q.fgot;

    AST_ACCESS_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (mem_addr >= ctl_q.lo && mem_addr <= ctl_q.hi));  // R10
    AST_QUIET_UNLESS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_en);  // R1
    AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));  // R9
    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> (fail && $stable(fail_addr) && $stable(fail_got)));  // R9
    AST_FAIL_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> $past(mem_en && !mem_we, 2));  // R9
    AST_WALK_SINGLE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && ctl_q.alg == ALG_WALK) |-> ($countones(mem_wdata) == 1));  // R7
    AST_SECOND_CLASS_ALG: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && fail_second) |-> (fail_alg == 3'd1 || fail_alg == 3'd2 || fail_alg == 3'd4));  // R5
    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(ctl_q.lo) && $stable(ctl_q.hi)));  // R11
endmodule

// File: tb/tb_mbist_engine.sv
module tb_mbist_engine;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam logic [31:0] SEED = 32'hC0FFEE01;
    localparam logic [31:0] TAPS = 32'h80200003;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] range_lo = '0, range_hi = '0;
    logic mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic busy, done, fail, fail_second;
    logic [2:0] fail_alg;
    logic [AW-1:0] fail_addr;
    logic [DW-1:0] fail_exp, fail_got;

    always #4 clk = ~clk;

    mbist_engine #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .range_lo(range_lo), .range_hi(range_hi),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .fail(fail),
        .fail_second(fail_second), .fail_alg(fail_alg), .fail_addr(fail_addr),
        .fail_exp(fail_exp), .fail_got(fail_got)
    );

    int n_vec = 0;
    int n_err = 0;

    logic [DW-1:0] mem [256];
    bit            prefill_req = 1'b0;
    bit            sa_on = 0, sa_one = 0;  int sa_addr = 0, sa_bit = 0;
    bit            al_on = 0;              int al_src = 0, al_dst = 0;
    bit            br_on = 0;              int br_addr = 0;
    bit            fl_on = 0;              int fl_addr = 0; logic [31:0] fl_mask = 0;
    int            fl_cnt = 0;

    function automatic logic [31:0] sentinel(input int a);
        return 32'hDEAD0000 ^ (a * 32'h00010101);
    endfunction

    function automatic logic [31:0] lfsr_next(input logic [31:0] s);
        return (s >> 1) ^ (s[0] ? TAPS : 32'h0);
    endfunction

    always @(posedge clk) begin
        if (prefill_req) begin
            for (int i = 0; i < 256; i++) mem[i] <= sentinel(i);
            fl_cnt = 0;
        end else if (mem_en) begin
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                if (al_on && int'(mem_addr) == al_src) mem[al_dst] <= mem_wdata;
            end else begin
                logic [31:0] rd;
                rd = mem[mem_addr];
                if (sa_on && int'(mem_addr) == sa_addr) begin
                    if (sa_one) rd[sa_bit] = 1'b1; else rd[sa_bit] = 1'b0;
                end
                if (br_on && int'(mem_addr) == br_addr) rd[4] = rd[4] | rd[20];
                mem_rdata <= rd;
                if (fl_on && int'(mem_addr) == fl_addr) begin
                    fl_cnt = fl_cnt + 1;
                    if (fl_cnt == 5) mem[fl_addr] <= mem[fl_addr] ^ fl_mask;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic clear_faults();
        sa_on = 0; al_on = 0; br_on = 0; fl_on = 0;
    endtask

    int busy_c, en_c, we_c;

    task automatic run(input int lo, input int hi, input int poke_at);
        @(negedge clk); prefill_req = 1'b1;
        @(negedge clk); prefill_req = 1'b0;
        range_lo = AW'(lo); range_hi = AW'(hi); start = 1'b1;
        @(negedge clk); start = 1'b0;
        busy_c = 0; en_c = 0; we_c = 0;
        for (int t = 0; t < 60000; t++) begin
            if (done || fail) break;
            busy_c += int'(busy); en_c += int'(mem_en); we_c += int'(mem_en && mem_we);
            if (t == poke_at) begin range_lo = 8'd0; range_hi = 8'd255; start = 1'b1; end
            @(negedge clk);
            start = 1'b0;
        end
    endtask

    task automatic clean_run(input int lo, input int hi, input int poke_at);
        int n;
        logic [31:0] s;
        bit ok_in, ok_out;
        logic [31:0] bad_act, bad_exp;
        n = hi - lo + 1;
        clear_faults();
        run(lo, hi, poke_at);
        chk(done && !fail, "R2", "clean run ends done", {30'd0, fail, done}, 32'd1);
        chk(en_c == 90 * n, "R2", "access count", en_c, 90 * n);
        chk(we_c == 42 * n, "R2", "write count", we_c, 42 * n);
        chk(busy_c == 90 * n + 1, "R2", "busy cycles", busy_c, 90 * n + 1);
        s = SEED; ok_in = 1; bad_act = 0; bad_exp = 0;
        for (int i = 0; i < n; i++) begin
            if (mem[lo + i] !== s && ok_in) begin ok_in = 0; bad_act = mem[lo + i]; bad_exp = s; end
            s = lfsr_next(s);
        end
        chk(ok_in, "R8", "random contents", bad_act, bad_exp);
        ok_out = 1;
        for (int a = 0; a < 256; a++)
            if ((a < lo || a > hi) && mem[a] !== sentinel(a) && ok_out) begin
                ok_out = 0; bad_act = mem[a]; bad_exp = sentinel(a);
            end
        chk(ok_out, "R10", "outside window untouched", bad_act, bad_exp);
    endtask

    task automatic fault_check(input string req, input int lo, input int hi,
                               input logic [2:0] alg, input bit sec, input int addr,
                               input logic [31:0] exp, input logic [31:0] got);
        run(lo, hi, -1);
        chk(fail && !done, req, "stops with fail", {30'd0, done, fail}, 32'd1);
        chk(fail_alg == alg, req, "fail_alg", fail_alg, alg);
        chk(fail_second == sec, "R5", "error class", fail_second, sec);
        chk(int'(fail_addr) == addr, req, "fail_addr", fail_addr, addr);
        chk(fail_exp == exp, req, "fail_exp", fail_exp, exp);
        chk(fail_got == got, req, "fail_got", fail_got, got);
        repeat (3) @(negedge clk);
        chk(fail && fail_addr == AW'(addr), "R9", "report holds", fail_addr, addr);
    endtask

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        n_vec++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin : main
        int lo, hi, x, b;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !fail && !mem_en, "R1", "reset state",
            {28'd0, busy, done, fail, mem_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_en, "R1", "idle after reset", {30'd0, busy, mem_en}, 32'd0);

        // R2 R8 R10: directed full space and small windows
        clean_run(0, 255, -1);
        clean_run(7, 7, -1);
        // R11: start mid-run with another window is ignored
        clean_run(40, 60, 100);
        for (int k = 0; k < 6; k++) begin
            lo = int'($urandom_range(0, 200));
            hi = lo + int'($urandom_range(0, 40));
            clean_run(lo, hi, -1);
        end

        // R10: empty window
        clear_faults();
        run(20, 10, -1);
        chk(done && !fail, "R10", "empty window done", {30'd0, fail, done}, 32'd1);
        chk(en_c == 0, "R10", "empty window accesses", en_c, 0);
        chk(busy_c == 1, "R10", "empty window busy", busy_c, 1);

        // R3: random stuck-at faults caught by the fixed words
        for (int k = 0; k < 6; k++) begin
            lo = int'($urandom_range(0, 200));
            hi = lo + int'($urandom_range(1, 40));
            x = int'($urandom_range(lo, hi));
            b = int'($urandom_range(0, 31));
            clear_faults();
            sa_on = 1; sa_addr = x; sa_bit = b; sa_one = bit'($urandom_range(0, 1));
            if (sa_one) fault_check("R3", lo, hi, 3'd0, 1'b0, x, 32'h0, 32'h1 << b);
            else        fault_check("R3", lo, hi, 3'd0, 1'b0, x, 32'hFFFFFFFF, ~(32'h1 << b));
        end

        // R4: write to 21 also lands on 20; only the pair algorithm sees it
        clear_faults(); al_on = 1; al_src = 21; al_dst = 20;
        fault_check("R4", 16, 40, 3'd1, 1'b0, 20, 32'h0, 32'hFFFFFFFF);

        // R6: write to 23 also lands on 21; only address-as-data sees it
        clear_faults(); al_on = 1; al_src = 23; al_dst = 21;
        fault_check("R6", 16, 40, 3'd2, 1'b0, 21, 32'd21, 32'd23);

        // R7: bit 20 bleeds into bit 4 on read of 33
        clear_faults(); br_on = 1; br_addr = 33;
        fault_check("R7", 30, 45, 3'd3, 1'b0, 33, 32'h0010_0000, 32'h0010_0010);

        // R5: cell 6 flips after its fifth read (second pass of pair word 0)
        clear_faults(); fl_on = 1; fl_addr = 6; fl_mask = 32'h0000_0100;
        fault_check("R4", 0, 15, 3'd1, 1'b1, 6, 32'h0, 32'h0000_0100);

        // R12: restart after fail gives a fresh clean run
        clean_run(100, 110, -1);
        chk(!fail_second, "R12", "class cleared on restart", fail_second, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule